// File: doc/BRIEF.md
# PWM Periodic Compare-Match Unit Bank

This block holds a bank of independent comparison units that all watch one shared PWM reference counter. Each unit fires a single-clock match pulse when the reference counter reaches the unit's programmed compare value. A match is allowed only if four things hold:

- the unit is enabled;
- no fault is active on the reference channel;
- in center-aligned mode, the count direction agrees with the unit's direction bit;
- the unit's period-skip counter currently sits on its target slot.

The match pulses drive event lines, used for example for converter synchronization, and DMA requests. Each match also sets a sticky per-unit interrupt flag.

Software reaches each unit through a small write port that has two settings groups. The mode group holds the enable, the period maximum and the period target. The value group holds the compare value and the direction bit. Writes go into shadow copies and raise a per-unit pending flag. The shadow copies become active at the next reference period-end strobe, so a running channel never sees a setting change in the middle of a period. The reference counter is generated outside this block.

Top module: `pwm_cmp_bank`

## Requirements
- R1: An enabled unit whose target slot is armed and whose compare value equals `ref_cnt` drives its `match_evt` bit high for exactly one clock, in the cycle after the equality is presented. If the equality is held for several cycles, the unit still gives only one pulse.
- R2: A unit with its active enable at 0 never pulses and never sets its interrupt flag.
- R3: When `center_mode` is 1, direction bit 0 lets a unit match only while `count_down` is 0. Direction bit 1 lets it match only while `count_down` is 1.
- R4: When `center_mode` is 0, the direction bit has no effect: a unit with direction bit 1 matches while counting up.
- R5: While `fault` is 1, no unit matches.
- R6: Each unit has a period counter. The counter advances at each `period_end` while the unit is enabled and wraps to 0 after reaching the period maximum. It starts at 0 in the first enabled period. The unit compares only in periods where this counter equals the period target. With maximum 2 and target 1, matches occur in the 2nd and 5th of six periods.
- R7: With period maximum 0 and period target 0, the unit compares in every period.
- R8: A write with `cfg_sel`=0 loads the mode shadow (enable, maximum, target). A write with `cfg_sel`=1 loads the value shadow (compare value, direction). Either write sets that unit's `upd_pend` bit. Shadow contents become active only at `period_end`, and `upd_pend` clears there. A compare value written in mid-period therefore takes effect only from the next period.
- R9: Every match pulse sets the unit's `irq_flags` bit. The bit stays set until `sts_rd` is pulsed, which clears all flags. A match in the same cycle as the clear wins.
- R10: A unit's period counter is held at 0 while the unit is disabled. After re-enabling, the schedule restarts from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_cnt | input | CW | Shared reference counter value |
| center_mode | input | 1 | 1 = reference counter is center-aligned |
| count_down | input | 1 | 1 = reference counter is decrementing |
| period_end | input | 1 | One-cycle strobe at the end of a reference period |
| fault | input | 1 | Fault active on the reference channel |
| cfg_wr | input | 1 | Write strobe for the shadow settings |
| cfg_sel | input | 1 | 0 = mode group, 1 = value group |
| cfg_unit | input | UW | Unit index being written |
| cfg_en | input | 1 | Enable (mode group) |
| cfg_pmax | input | PW | Period maximum (mode group) |
| cfg_ptgt | input | PW | Period target (mode group) |
| cfg_val | input | CW | Compare value (value group) |
| cfg_dir | input | 1 | Direction bit (value group) |
| sts_rd | input | 1 | Status read; clears all interrupt flags |
| match_evt | output | N | One-clock match pulse per unit |
| irq_flags | output | N | Sticky interrupt flag per unit |
| upd_pend | output | N | Shadow update waiting for period end, per unit |

## Verification
The bench aims at the period-skip schedule. An off-by-one in the wrap would move matches to the wrong periods. An un-reset period counter would fire in the very first period after a re-enable. The bench also checks the shadow rule: a design that copied writes immediately would report the new compare value within the period of the write. Center-aligned direction qualification is checked by recording the count direction at each pulse, which catches a design that swapped or ignored the direction bit. A reference value held for several cycles would expose a level output in place of a pulse. A fault window shows whether the fault path really suppresses matching.

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int N  = 8,
  parameter int CW = 16,
  parameter int PW = 4,
  localparam int UW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ref_cnt,
  input  logic          center_mode,
  input  logic          count_down,
  input  logic          period_end,
  input  logic          fault,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [UW-1:0] cfg_unit,
  input  logic          cfg_en,
  input  logic [PW-1:0] cfg_pmax,
  input  logic [PW-1:0] cfg_ptgt,
  input  logic [CW-1:0] cfg_val,
  input  logic          cfg_dir,
  input  logic          sts_rd,
  output logic [N-1:0]  match_evt,
  output logic [N-1:0]  irq_flags,
  output logic [N-1:0]  upd_pend
);

  logic [N-1:0] hit_v, hit_q, en_v;
  wire  [N-1:0] rise = hit_v & ~hit_q;

  for (genvar u = 0; u < N; u++) begin : g_unit
    logic          a_en, a_dir, s_en, s_dir, pm, pv;
    logic [PW-1:0] a_pmax, a_ptgt, s_pmax, s_ptgt, pcnt;
    logic [CW-1:0] a_val, s_val;
    wire           sel_me = cfg_wr && (cfg_unit == UW'(u));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        {a_en, a_dir, s_en, s_dir, pm, pv} <= '0;
        {a_pmax, a_ptgt, s_pmax, s_ptgt, pcnt} <= '0;
        a_val <= '0;
        s_val <= '0;
      end else begin
        if (!a_en)
          pcnt <= '0;
        else if (period_end)
          pcnt <= (pcnt >= a_pmax) ? '0 : pcnt + 1'b1;
        if (period_end) begin
          if (pm) {a_en, a_pmax, a_ptgt} <= {s_en, s_pmax, s_ptgt};
          if (pv) {a_val, a_dir} <= {s_val, s_dir};
          pm <= 1'b0;
          pv <= 1'b0;
        end
        if (sel_me && !cfg_sel) begin
          {s_en, s_pmax, s_ptgt} <= {cfg_en, cfg_pmax, cfg_ptgt};
          pm <= 1'b1;
        end
        if (sel_me && cfg_sel) begin
          {s_val, s_dir} <= {cfg_val, cfg_dir};
          pv <= 1'b1;
        end
      end
    end

    assign hit_v[u] = a_en && !fault && (ref_cnt == a_val) && (pcnt == a_ptgt)
                      && (!center_mode || (count_down == a_dir));
    assign en_v[u]     = a_en;
    assign upd_pend[u] = pm | pv;

    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !a_en |=> !match_evt[u]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q     <= '0;
      match_evt <= '0;
      irq_flags <= '0;
    end else begin
      hit_q     <= hit_v;
      match_evt <= rise;
      irq_flags <= (irq_flags & ~{N{sts_rd}}) | rise;
    end
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt & $past(match_evt)) == '0);
  p_fault_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> match_evt == '0);
  p_pend_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !cfg_wr) |=> upd_pend == '0);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt & ~irq_flags) == '0);
  p_enable_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt & ~$past(en_v)) == '0);

endmodule

// File: tb/test_pwm_cmp_bank.sv
module test_pwm_cmp_bank;
  localparam int CLK_P = 10;
  localparam int N = 8, CW = 16, PW = 4, UW = 3;
  localparam logic [CW-1:0] IDLE = 16'hFFFF;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] ref_cnt = IDLE;
  logic center_mode = 0, count_down = 0, period_end = 0, fault = 0;
  logic cfg_wr = 0, cfg_sel = 0, cfg_en = 0, cfg_dir = 0, sts_rd = 0;
  logic [UW-1:0] cfg_unit = '0;
  logic [PW-1:0] cfg_pmax = '0, cfg_ptgt = '0;
  logic [CW-1:0] cfg_val = '0;
  logic [N-1:0] match_evt, irq_flags, upd_pend;

  int n_chk = 0, n_bad = 0;
  int pulses [N];
  logic [CW-1:0] last_ref [N];
  logic last_dn [N];
  logic [CW-1:0] cur_ref = IDLE;
  logic cur_dn = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_cmp_bank #(.N(N), .CW(CW), .PW(PW)) i_pwm_cmp_bank (
    .clk(clk), .rst_n(rst_n), .ref_cnt(ref_cnt), .center_mode(center_mode),
    .count_down(count_down), .period_end(period_end), .fault(fault),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_unit(cfg_unit), .cfg_en(cfg_en),
    .cfg_pmax(cfg_pmax), .cfg_ptgt(cfg_ptgt), .cfg_val(cfg_val), .cfg_dir(cfg_dir),
    .sts_rd(sts_rd), .match_evt(match_evt), .irq_flags(irq_flags), .upd_pend(upd_pend));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick(input logic [CW-1:0] r, input logic dn, input logic pe);
    @(negedge clk);
    for (int u = 0; u < N; u++)
      if (match_evt[u]) begin
        pulses[u]++;
        last_ref[u] = cur_ref;
        last_dn[u] = cur_dn;
      end
    cur_ref = r; cur_dn = dn;
    ref_cnt = r; count_down = dn; period_end = pe;
    cfg_wr = 0; sts_rd = 0;
  endtask

  task automatic idle(); tick(IDLE, 0, 0); endtask
  task automatic load(); tick(IDLE, 0, 1); idle(); endtask

  task automatic clr_counts();
    for (int u = 0; u < N; u++) begin pulses[u] = 0; last_ref[u] = IDLE; last_dn[u] = 0; end
  endtask

  task automatic wr_mode(input int u, input logic en, input int pmax, input int ptgt);
    idle();
    cfg_wr = 1; cfg_sel = 0; cfg_unit = UW'(u); cfg_en = en;
    cfg_pmax = PW'(pmax); cfg_ptgt = PW'(ptgt);
  endtask

  task automatic wr_val(input int u, input int val, input logic dir);
    idle();
    cfg_wr = 1; cfg_sel = 1; cfg_unit = UW'(u); cfg_val = CW'(val); cfg_dir = dir;
  endtask

  task automatic left_periods(input int n);
    for (int p = 0; p < n; p++)
      for (int i = 0; i < 10; i++) tick(CW'(i), 0, i == 9);
    idle();
  endtask

  task automatic center_periods(input int n);
    for (int p = 0; p < n; p++) begin
      for (int i = 0; i < 8; i++) tick(CW'(i), 0, 0);
      for (int i = 8; i >= 1; i--) tick(CW'(i), 1, i == 1);
    end
    idle();
  endtask

  task automatic t_reset();
    idle();
    chk("R1 reset match", int'(match_evt), 0);
    chk("R9 reset irq", int'(irq_flags), 0);
    chk("R8 reset pend", int'(upd_pend), 0);
  endtask

  task automatic t_basic();
    wr_mode(0, 1, 0, 0);
    idle();
    chk("R8 pend after write", int'(upd_pend[0]), 1);
    wr_val(0, 5, 1);
    load();
    chk("R8 pend cleared at period end", int'(upd_pend[0]), 0);
    clr_counts();
    left_periods(4);
    chk("R7 every period", pulses[0], 4);
    chk("R4 left mode ignores dir", int'(last_ref[0]), 5);
    chk("R9 irq set", int'(irq_flags[0]), 1);
  endtask

  task automatic t_hold();
    clr_counts();
    repeat (3) tick(5, 0, 0);
    idle(); idle();
    chk("R1 held equality single pulse", pulses[0], 1);
  endtask

  task automatic t_irq_clear();
    idle();
    sts_rd = 1;
    idle();
    chk("R9 irq cleared by read", int'(irq_flags[0]), 0);
  endtask

  task automatic t_disabled();
    wr_mode(1, 0, 0, 0);
    wr_val(1, 5, 0);
    load();
    clr_counts();
    left_periods(2);
    chk("R2 disabled no pulse", pulses[1], 0);
    chk("R2 disabled no irq", int'(irq_flags[1]), 0);
  endtask

  task automatic t_center();
    wr_mode(2, 1, 0, 0); wr_val(2, 3, 1);
    wr_mode(3, 1, 0, 0); wr_val(3, 3, 0);
    load();
    center_mode = 1;
    clr_counts();
    center_periods(3);
    chk("R3 down unit count", pulses[2], 3);
    chk("R3 down unit direction", int'(last_dn[2]), 1);
    chk("R3 up unit count", pulses[3], 3);
    chk("R3 up unit direction", int'(last_dn[3]), 0);
    center_mode = 0;
  endtask

  task automatic t_skip();
    wr_mode(4, 1, 2, 1); wr_val(4, 5, 0);
    load();
    clr_counts();
    left_periods(1);
    chk("R6 slot0 no match", pulses[4], 0);
    left_periods(1);
    chk("R6 slot1 match", pulses[4], 1);
    left_periods(4);
    chk("R6 six periods two matches", pulses[4], 2);
  endtask

  task automatic t_reenable();
    left_periods(1);
    wr_mode(4, 0, 2, 1);
    load();
    idle(); idle();
    wr_mode(4, 1, 2, 1);
    load();
    clr_counts();
    left_periods(1);
    chk("R10 restart slot0 no match", pulses[4], 0);
    left_periods(1);
    chk("R10 restart slot1 match", pulses[4], 1);
  endtask

  task automatic t_fault();
    clr_counts();
    fault = 1;
    left_periods(2);
    chk("R5 fault suppresses", pulses[0], 0);
    fault = 0;
    left_periods(1);
    chk("R5 match after fault", pulses[0], 1);
  endtask

  task automatic t_shadow();
    clr_counts();
    for (int i = 0; i < 3; i++) tick(CW'(i), 0, 0);
    cfg_wr = 1; cfg_sel = 1; cfg_unit = 0; cfg_val = 7; cfg_dir = 0;
    for (int i = 3; i < 10; i++) tick(CW'(i), 0, i == 9);
    idle();
    chk("R8 old value this period", int'(last_ref[0]), 5);
    chk("R8 one pulse this period", pulses[0], 1);
    left_periods(1);
    chk("R8 new value next period", int'(last_ref[0]), 7);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    clr_counts();
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_hold();
    t_irq_clear();
    t_disabled();
    t_center();
    t_skip();
    t_reenable();
    t_fault();
    t_shadow();
    summary();
  end
endmodule